// File: doc/BRIEF.md
# Disk Controller I/O Address Decoder

This block sits between a host I/O port and the register files of a two-channel disk controller. It takes one access at a time, 1, 2 or 4 bytes wide. It compares the address against five programmable windows and fires a one-hot strobe toward the matching target, with the window-relative offset attached. The five windows are command and control for each of the two channels, plus one bus-master window. The bus-master window is split into a lower half for the first channel and an upper half for the second, so the decoder has six targets.

Each channel carries two devices, a master and a slave. The decoder watches host writes to the device-select offset of each command window and keeps its own record of which device is selected. When the selected device is not present, the decoder returns zero for reads and never strobes the channel. Traffic as a whole is gated by an I/O enable. Bus-master writes are further gated by a bus-master enable. Both enables come from a command register written over the same configuration port as the window bases.

The strobe, offset and response are combinational in the current access cycle. Window bases, enables and device selections update on the clock edge that ends the cycle.

Top module: `dcd_io_decoder`

## Requirements
- R1: Windows are tested in the fixed order first-channel command (span 8), first-channel control (span 4), second-channel command (8), second-channel control (4), bus-master (16). A window matches when base <= addr < base + span, and only the first match is taken. The strobe bits are, from bit 0 upward: first command, first control, second command, second control, bus-master first half, bus-master second half. At most one strobe bit is ever high.
- R2: While the I/O enable is clear, an access produces no strobe, no error and zero read data, and it does not change any device selection.
- R3: While the bus-master enable is clear, a write that hits the bus-master window produces no strobe and no error. A read of that window is still strobed.
- R4: A bus-master window offset below 8 strobes bit 4 with that offset. An offset of 8 or more strobes bit 5 with the offset minus 8.
- R5: A legal-size write that hits a channel's command window at offset 6 loads that channel's device select from write-data bit 4 (0 = master, 1 = slave). This happens even when that device is absent. No other access changes the selection. tgt_dev shows the selection of the accessed channel.
- R6: dev_present bits are, from bit 0 upward: first master, first slave, second master, second slave. A command or control access whose selected device is absent gives no strobe and zero read data. It raises rsp_err unless the size is one byte.
- R7: req_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The value 3 is illegal: it raises rsp_err when I/O is enabled and never produces a strobe.
- R8: A configuration write with cfg_idx 0..4 loads the base of the window with that priority index, but only when the data is nonzero. cfg_idx 5 loads the command register: data bit 0 is the I/O enable and bit 2 is the bus-master enable.
- R9: An enabled, legal-size access that matches no window raises rsp_err and returns zero read data with no strobe.
- R10: After reset all window bases are 0, both enables are clear, and both channels select the master device.
- R11: With a strobe high, tgt_off is the address minus the matched window's base (less 8 in the bus-master upper half). rsp_rdata equals dev_rdata on a strobed read. Without a strobe, tgt_off and rsp_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | 0..4 window base, 5 command register |
| cfg_wdata | input | AW | Configuration write data |
| req_valid | input | 1 | Host access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | AW | Host I/O address |
| req_wdata | input | 32 | Host write data |
| dev_present | input | 4 | Device presence per channel and position |
| dev_rdata | input | 32 | Read data returned by the strobed target |
| tgt_stb | output | 6 | One-hot target strobe |
| tgt_off | output | AW | Offset within the target |
| tgt_dev | output | 1 | Selected device of the accessed channel |
| rsp_rdata | output | 32 | Read data to the host |
| rsp_err | output | 1 | Access error |

## Verification
On every cycle, the embedded assertions check several rules. At most one strobe is high. Nothing strobes or errors while I/O is disabled. A bus-master write strobe never appears with the bus-master enable clear. An absent device is never strobed and yields zero data. A device selection moves only on a snooped select write. A zero configuration write leaves a base untouched. Only the bench's scenarios can show the rest: priority among overlapping windows, the exact offsets, the split point of the bus-master window, and that the select bit is taken from bit 4 at offset 6. The bench checks these against a reference model under random addresses, sizes, presence patterns and base layouts.

// File: rtl/dcd_pkg.sv
// Package: shared constants and the access-size encoding for the I/O decoder.
// Assumes five windows in fixed priority order and six downstream targets.
package dcd_pkg;
    localparam int NUM_WIN     = 5;
    localparam int NUM_TGT     = 6;
    localparam int WIN_P_CMD   = 0;
    localparam int WIN_P_CTL   = 1;
    localparam int WIN_S_CMD   = 2;
    localparam int WIN_S_CTL   = 3;
    localparam int WIN_BM      = 4;
    localparam int TGT_BM_LO   = 4;
    localparam int TGT_BM_HI   = 5;
    localparam int CFG_CMD_IDX = 5;
    localparam int IOEN_BIT    = 0;
    localparam int BMEN_BIT    = 2;
    localparam int SEL_OFFSET  = 6;
    localparam int SEL_BIT     = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;
endpackage

// File: rtl/dcd_cfg_regs.sv
// Module: holds the five window bases and the two enables.
// Assumes a base write of zero must be ignored; the command register takes
// the I/O enable and bus-master enable from fixed data bits.
module dcd_cfg_regs
    import dcd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_wr,
    input  logic [2:0]                  cfg_idx,
    input  logic [AW-1:0]               cfg_wdata,
    output logic [NUM_WIN-1:0][AW-1:0]  base_q,
    output logic                        io_en,
    output logic                        bm_en
);

    genvar k;
    generate
        for (k = 0; k < NUM_WIN; k++) begin : g_base
            // Load one window base on a nonzero write to its index.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    base_q[k] <= '0;
                else if (cfg_wr && (cfg_idx == 3'(k)) && (cfg_wdata != '0))
                    base_q[k] <= cfg_wdata;
            end

            AST_BASE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_wr && (cfg_idx == 3'(k)) && (cfg_wdata == '0)) |=> $stable(base_q[k])); // R8
        end
    endgenerate

    // Capture the two enables from a command register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_en <= 1'b0;
            bm_en <= 1'b0;
        end else if (cfg_wr && (cfg_idx == 3'(CFG_CMD_IDX))) begin
            io_en <= cfg_wdata[IOEN_BIT];
            bm_en <= cfg_wdata[BMEN_BIT];
        end
    end

endmodule

// File: rtl/dcd_window_match.sv
// Module: compares the address against every window in parallel and picks
// the lowest-index hit. Assumes spans fit in AW bits; the compare is widened
// by one bit so a window near the top of the space does not wrap.
module dcd_window_match
    import dcd_pkg::*;
#(
    parameter int AW       = 16,
    parameter int CMD_SPAN = 8,
    parameter int CTL_SPAN = 4,
    parameter int BM_SPAN  = 16
) (
    input  logic [AW-1:0]               addr,
    input  logic [NUM_WIN-1:0][AW-1:0]  base_q,
    output logic                        win_hit,
    output logic [2:0]                  win_idx,
    output logic [AW-1:0]               win_off
);

    function automatic int span_of(input int k);
        if (k == WIN_BM)
            return BM_SPAN;
        else if ((k == WIN_P_CMD) || (k == WIN_S_CMD))
            return CMD_SPAN;
        else
            return CTL_SPAN;
    endfunction

    logic [NUM_WIN-1:0] hit_vec;

    genvar k;
    generate
        for (k = 0; k < NUM_WIN; k++) begin : g_cmp
            localparam logic [AW:0] SPAN_W = (AW+1)'(span_of(k));
            logic [AW:0] lo_w;
            logic [AW:0] hi_w;
            assign lo_w       = {1'b0, base_q[k]};
            assign hi_w       = lo_w + SPAN_W;
            assign hit_vec[k] = ({1'b0, addr} >= lo_w) && ({1'b0, addr} < hi_w);
        end
    endgenerate

    // Priority pick: the lowest window index that hits wins.
    always_comb begin
        win_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i])
                win_idx = 3'(i);
        end
    end

    assign win_hit = |hit_vec;

    // Offset of the address within the chosen window.
    always_comb begin
        win_off = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_idx == 3'(i))
                win_off = addr - base_q[i];
        end
    end

endmodule

// File: rtl/dcd_dev_select.sv
// Module: one device-select flag per channel, loaded from snooped writes.
// Assumes the top decides when a write is a select write; this block only
// stores the chosen bit.
module dcd_dev_select #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] upd_en,
    input  logic              upd_val,
    output logic [NUM_CH-1:0] sel_q
);

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            // Store the selected device of one channel; master after reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sel_q[c] <= 1'b0;
                else if (upd_en[c])
                    sel_q[c] <= upd_val;
            end

            AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !upd_en[c] |=> $stable(sel_q[c])); // R5
        end
    endgenerate

endmodule

// File: rtl/dcd_io_decoder.sv
// Module: top of the I/O address decoder. Routes one host access per cycle
// to a one-hot target strobe with a local offset, snoops device-select
// writes and applies the enable, size and presence rules.
// Assumes the target returns read data combinationally on dev_rdata.
module dcd_io_decoder
    import dcd_pkg::*;
#(
    parameter int AW       = 16,
    parameter int CMD_SPAN = 8,
    parameter int CTL_SPAN = 4,
    parameter int BM_SPAN  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_idx,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    input  logic [3:0]    dev_present,
    input  logic [31:0]   dev_rdata,
    output logic [5:0]    tgt_stb,
    output logic [AW-1:0] tgt_off,
    output logic          tgt_dev,
    output logic [31:0]   rsp_rdata,
    output logic          rsp_err
);

    localparam int BM_HALF = BM_SPAN / 2;

    logic [NUM_WIN-1:0][AW-1:0] base_q;
    logic                       io_en;
    logic                       bm_en;
    logic                       win_hit;
    logic [2:0]                 win_idx;
    logic [AW-1:0]              win_off;
    logic [1:0]                 sel_q;
    logic [1:0]                 sel_upd;

    logic                       active;
    logic                       legal;
    logic                       chan_win;
    logic                       ch;
    logic                       cur_sel;
    logic                       present;

    dcd_cfg_regs #(.AW(AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .io_en     (io_en),
        .bm_en     (bm_en)
    );

    dcd_window_match #(
        .AW       (AW),
        .CMD_SPAN (CMD_SPAN),
        .CTL_SPAN (CTL_SPAN),
        .BM_SPAN  (BM_SPAN)
    ) u_match (
        .addr    (req_addr),
        .base_q  (base_q),
        .win_hit (win_hit),
        .win_idx (win_idx),
        .win_off (win_off)
    );

    dcd_dev_select #(.NUM_CH(2)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (sel_upd),
        .upd_val (req_wdata[SEL_BIT]),
        .sel_q   (sel_q)
    );

    // Classify the access: enabled, legal size, channel and device presence.
    always_comb begin
        active   = req_valid && io_en;
        legal    = (req_size != SZ_BAD);
        chan_win = win_hit && (win_idx != 3'(WIN_BM));
        ch       = (win_idx == 3'(WIN_S_CMD)) || (win_idx == 3'(WIN_S_CTL));
        cur_sel  = sel_q[ch];
        present  = dev_present[{ch, cur_sel}];
    end

    // Detect select writes at the select offset of either command window.
    always_comb begin
        sel_upd = '0;
        if (active && legal && req_write && win_hit && (win_off == AW'(SEL_OFFSET))) begin
            if (win_idx == 3'(WIN_P_CMD)) sel_upd[0] = 1'b1;
            if (win_idx == 3'(WIN_S_CMD)) sel_upd[1] = 1'b1;
        end
    end

    // Route the access to one target and form the host response.
    always_comb begin
        tgt_stb   = '0;
        tgt_off   = '0;
        tgt_dev   = 1'b0;
        rsp_rdata = '0;
        rsp_err   = 1'b0;
        if (active) begin
            if (!legal) begin
                rsp_err = 1'b1;
            end else if (!win_hit) begin
                rsp_err = 1'b1;
            end else if (chan_win) begin
                if (present) begin
                    tgt_stb[win_idx] = 1'b1;
                    tgt_off          = win_off;
                    tgt_dev          = cur_sel;
                    if (!req_write)
                        rsp_rdata = dev_rdata;
                end else begin
                    rsp_err = (req_size != SZ_BYTE);
                end
            end else if (!(req_write && !bm_en)) begin
                if (win_off < AW'(BM_HALF)) begin
                    tgt_stb[TGT_BM_LO] = 1'b1;
                    tgt_off            = win_off;
                end else begin
                    tgt_stb[TGT_BM_HI] = 1'b1;
                    tgt_off            = win_off - AW'(BM_HALF);
                end
                if (!req_write)
                    rsp_rdata = dev_rdata;
            end
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_stb)); // R1
    AST_IO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en |-> ((tgt_stb == '0) && !rsp_err && (rsp_rdata == '0))); // R2
    AST_BM_WR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_write && !bm_en) |-> (tgt_stb[TGT_BM_HI:TGT_BM_LO] == 2'b00)); // R3
    AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_win && !present) |-> ((tgt_stb == '0) && (rsp_rdata == '0))); // R6
    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == SZ_BAD) |-> (tgt_stb == '0)); // R7

endmodule

// File: tb/dcd_io_decoder_tb.sv
module dcd_io_decoder_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [3:0]    dev_present = '0;
    logic [31:0]   dev_rdata = '0;
    logic [5:0]    tgt_stb;
    logic [AW-1:0] tgt_off;
    logic          tgt_dev;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state mirrored from the requirements.
    logic [AW-1:0] m_base [5];
    logic          m_io, m_bm;
    logic [1:0]    m_sel;

    // Expected response of one access.
    logic [5:0]    e_stb;
    logic [AW-1:0] e_off;
    logic          e_dev;
    logic [31:0]   e_rd;
    logic          e_err;
    string         e_tag;

    always #10 clk = ~clk;

    dcd_io_decoder #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .dev_present(dev_present), .dev_rdata(dev_rdata), .tgt_stb(tgt_stb),
        .tgt_off(tgt_off), .tgt_dev(tgt_dev), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    function automatic int span(input int k);
        return (k == 4) ? 16 : ((k == 0 || k == 2) ? 8 : 4);
    endfunction

    task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // Compute the expected outputs and the select update of one access.
    task automatic model(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                         input logic [31:0] wd, input logic [3:0] pres, input logic [31:0] rd,
                         output logic upd, output int upd_ch);
        int k;
        logic [AW-1:0] off;
        int c;
        upd = 1'b0; upd_ch = 0;
        e_stb = '0; e_off = '0; e_dev = 1'b0; e_rd = '0; e_err = 1'b0;
        k = -1;
        for (int i = 4; i >= 0; i--)
            if ({1'b0, a} >= {1'b0, m_base[i]} && {1'b0, a} < {1'b0, m_base[i]} + 17'(span(i)))
                k = i;
        if (!m_io) begin e_tag = "R2"; return; end
        if (sz == 2'd3) begin e_err = 1'b1; e_tag = "R7"; return; end
        if (k < 0) begin e_err = 1'b1; e_tag = "R9"; return; end
        off = a - m_base[k];
        if (wr && (k == 0 || k == 2) && off == 6) begin upd = 1'b1; upd_ch = k / 2; end
        if (k < 4) begin
            c = k / 2;
            if (!pres[c*2 + int'(m_sel[c])]) begin
                e_err = (sz != 2'd0); e_tag = "R6"; return;
            end
            e_stb[k] = 1'b1; e_off = off; e_dev = m_sel[c];
            e_rd = wr ? 32'h0 : rd; e_tag = "R1";
        end else begin
            if (wr && !m_bm) begin e_tag = "R3"; return; end
            e_tag = "R4";
            if (off < 8) begin e_stb[4] = 1'b1; e_off = off; end
            else begin e_stb[5] = 1'b1; e_off = off - 8; end
            e_rd = wr ? 32'h0 : rd;
        end
    endtask

    task automatic cfg(input logic [2:0] idx, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(posedge clk);
        if (idx == 3'd5) begin m_io = d[0]; m_bm = d[2]; end
        else if (d != '0) m_base[idx] = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic access(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [31:0] wd, input logic [3:0] pres);
        logic upd;
        int uch;
        logic [31:0] rd;
        rd = $urandom;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_wdata = wd; dev_present = pres; dev_rdata = rd;
        model(wr, sz, a, wd, pres, rd, upd, uch);
        #5;
        check(e_tag, "strobe", 64'(tgt_stb), 64'(e_stb));
        check(e_tag, "error", 64'(rsp_err), 64'(e_err));
        check(e_tag, "rdata", 64'(rsp_rdata), 64'(e_rd));
        check("R11", "offset", 64'(tgt_off), 64'(e_off));
        check("R5", "device", 64'(tgt_dev), 64'(e_dev));
        @(posedge clk);
        if (upd) m_sel[uch] = wd[4];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 5; i++) m_base[i] = '0;
        m_io = 1'b0; m_bm = 1'b0; m_sel = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10: after reset nothing is enabled; an access is inert.
        access(1'b0, 2'd0, 16'h0003, 32'h0, 4'hF);
        check("R10", "reset strobe", 64'(tgt_stb), 64'h0);
        // R10: bases 0 and master selected once I/O is on.
        cfg(3'd5, 16'h0001);
        access(1'b0, 2'd0, 16'h0003, 32'h0, 4'b0001);
        check("R10", "reset base/sel", 64'(tgt_stb), 64'h1);

        // R8: layout with overlapping control window for R1 priority.
        cfg(3'd0, 16'h0100); cfg(3'd1, 16'h0104); cfg(3'd2, 16'h0200);
        cfg(3'd3, 16'h0300); cfg(3'd4, 16'h0400);
        cfg(3'd4, 16'h0000);  // R8: zero write ignored
        access(1'b0, 2'd1, 16'h0405, 32'h0, 4'hF);
        check("R8", "base kept", 64'(tgt_stb), 64'h10);
        access(1'b0, 2'd0, 16'h0105, 32'h0, 4'hF);  // R1 priority: command wins
        access(1'b0, 2'd0, 16'h0109, 32'h0, 4'hF);
        // R4 split and R3 gating
        access(1'b0, 2'd2, 16'h040C, 32'h0, 4'hF);
        access(1'b1, 2'd2, 16'h040C, 32'h0, 4'hF);
        cfg(3'd5, 16'h0005);
        access(1'b1, 2'd0, 16'h0407, 32'h0, 4'hF);
        access(1'b1, 2'd0, 16'h0408, 32'h0, 4'hF);
        // R5 select snoop, then R6 with slave absent
        access(1'b1, 2'd0, 16'h0206, 32'h10, 4'hF);
        access(1'b0, 2'd0, 16'h0201, 32'h0, 4'b0111);
        access(1'b0, 2'd1, 16'h0201, 32'h0, 4'b0111);
        access(1'b1, 2'd0, 16'h0206, 32'h10, 4'b0000);  // R5 absent still selects
        access(1'b1, 2'd0, 16'h0205, 32'h10, 4'hF);     // R5 other offset no change
        access(1'b1, 2'd0, 16'h0206, 32'hEF, 4'hF);     // back to master
        access(1'b0, 2'd3, 16'h0100, 32'h0, 4'hF);      // R7
        access(1'b0, 2'd0, 16'h0050, 32'h0, 4'hF);      // R9
        cfg(3'd5, 16'h0004);
        access(1'b1, 2'd0, 16'h0106, 32'h10, 4'hF);     // R2: no select change
        cfg(3'd5, 16'h0005);
        access(1'b0, 2'd0, 16'h0101, 32'h0, 4'hF);

        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a;
            if ($urandom_range(0, 99) < 3)
                cfg(3'($urandom_range(0, 4)), ($urandom_range(0, 3) == 0) ? 16'h0 : 16'(16'h0080 * $urandom_range(1, 10)));
            if ($urandom_range(0, 99) < 3)
                cfg(3'd5, ($urandom_range(0, 4) == 0) ? 16'h0004 : 16'(($urandom_range(0, 1) << 2) | 1));
            a = ($urandom_range(0, 9) == 0) ? 16'($urandom) : 16'($urandom_range(16'h0080, 16'h0540));
            access(1'($urandom), 2'($urandom), a, $urandom, 4'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule